// File: doc/BRIEF.md
# Interrupt Source Routing Table

This block is the source side of a two-level interrupt controller. It keeps one table entry per interrupt source: the server that should take the interrupt, the current priority, a saved priority, and four status flags (line asserted, delivered and not yet finished, refused by the server side, event seen while masked). Whether each source is level-sensitive or message-style is fixed by a parameter. The block turns line activity and configuration writes into delivery requests that carry a global source number, a server and a priority. Each request goes to the presentation stage over a valid/ready handshake.

The presentation stage reports back in three ways. It can refuse a source, signal end of service for a source, or ask for a replay. On a replay the block walks the whole table, one entry per clock, and re-offers whatever still needs service. While the walk runs it holds `busy` and stalls every other request. Source numbers seen outside the block are the table index plus a fixed base. Only one request is taken per clock, when `in_ready` is high. `in_ready` is low while a delivery is waiting or a walk is in progress.

Top module: `irq_source_table`

## Requirements
- R1: After reset every entry reads back server 0 and priority 0xFF, no delivery is pending, `busy` is low and `in_ready` is high. The level or message type of each source is a parameter and reset does not change it.
- R2: A message source treats `line_level`=1 as an event. If the entry's priority is 0xFF (masked), the event is latched as masked-pending and nothing is delivered. Otherwise a delivery is issued at once with the entry's server and priority. `line_level`=0 has no effect on a message source.
- R3: On a level source, `line_level` sets or clears the asserted flag. The entry fires only if it is unmasked, asserted and not already delivered. Firing sets the delivered flag and issues a delivery.
- R4: A refusal (`rej_valid`) for a source sets its refused flag and clears its delivered flag. It issues no delivery.
- R5: End of service (`eoi_valid`) clears the delivered flag of a level source. It does nothing to a message source and issues no delivery.
- R6: A replay request (`resend_req`) visits sources in ascending index order. A level source fires by the rule of R3. A message source with the refused flag has the flag cleared, and is delivered if unmasked. Deliveries come out in visit order.
- R7: Configuration op 0 (route) writes server, priority and saved priority. After the write, a message source that is masked-pending and now unmasked clears masked-pending and is delivered. A level source is re-checked by the rule of R3.
- R8: Op 2 (mute) sets the priority to 0xFF and moves the old priority into the saved priority. Op 3 (unmute) writes the saved priority into both fields and then re-checks the entry as in R7.
- R9: A configuration request is refused with `rsp_err`=1, and no state changes, when:
  - the source number lies outside [base, base+NUM_SRC), for any op;
  - for op 0, the server is at or above NUM_SERVERS;
  - for op 0, the priority exceeds 0xFF.
  A refused request reports server 0 and priority 0.
- R10: Every accepted configuration request gets exactly one response, one cycle after the accepting edge. Op 1 (query) changes nothing. On success the response returns the entry's server and priority as they stand after the op.
- R11: While `busy` or a delivery is pending, `in_ready` is low and requests are not taken. A configuration request driven then gets no response.
- R12: A delivery stays valid, with unchanged source, server and priority, until `dlv_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ready | output | 1 | Block takes one request this cycle |
| busy | output | 1 | Replay walk in progress |
| line_valid | input | 1 | Line activity for source `line_idx` |
| line_idx | input | IDX_W | Table index of the line |
| line_level | input | 1 | Line value or message event |
| cfg_valid | input | 1 | Configuration request |
| cfg_op | input | 2 | 0 route, 1 query, 2 mute, 3 unmute |
| cfg_src | input | SRC_W | Global source number |
| cfg_server | input | SRV_W | Target server (route) |
| cfg_prio | input | 9 | Priority (route), above 0xFF is illegal |
| rsp_valid | output | 1 | Configuration response |
| rsp_err | output | 1 | Parameter error |
| rsp_server | output | SRV_W | Entry server after the op |
| rsp_prio | output | 8 | Entry priority after the op |
| rej_valid | input | 1 | Refusal from presentation stage |
| rej_src | input | SRC_W | Refused global source number |
| eoi_valid | input | 1 | End of service |
| eoi_src | input | SRC_W | Finished global source number |
| resend_req | input | 1 | Start replay walk |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_src | output | SRC_W | Global source number |
| dlv_server | output | SRV_W | Target server |
| dlv_prio | output | 8 | Delivery priority |
| dlv_ready | input | 1 | Presentation stage takes the delivery |

## Verification
A request taken at a rising edge shows its configuration response and any delivery it causes right after that same edge. The bench therefore drives every input at a falling edge and reads the response and delivery flags at the next falling edge. It then pulses `dlv_ready` for one cycle to empty the slot before the next request.

A replay raises `busy` one edge after it is taken. Its deliveries arrive no sooner than one cycle apart. The bench drains them at falling edges and compares each one in order against a list it builds from its own model of the table. A long pseudo-random mix of every request kind, including illegal source numbers, servers and priorities, is scored against that model op by op.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

  typedef enum logic [1:0] {
    OP_ROUTE  = 2'd0,
    OP_QUERY  = 2'd1,
    OP_MUTE   = 2'd2,
    OP_UNMUTE = 2'd3
  } cfg_op_e;

  localparam logic [7:0] PRIO_OFF = 8'hFF;

  function automatic logic prio_live(input logic [7:0] p);
    return p != PRIO_OFF;
  endfunction

  // level entry needs a delivery: unmasked, line high, not yet in service
  function automatic logic level_fires(input logic [7:0] p, input logic asrt,
                                       input logic sent);
    return prio_live(p) && asrt && !sent;
  endfunction

  function automatic logic in_window(input logic [31:0] num,
                                     input logic [31:0] base,
                                     input logic [31:0] count);
    return (num >= base) && (num < base + count);
  endfunction

endpackage

// File: rtl/irqsrc_decode.sv
module irqsrc_decode #(
  parameter int SRC_W    = 16,
  parameter int IDX_W    = 3,
  parameter int SRC_BASE = 32'h1000,
  parameter int NUM_SRC  = 8
) (
  input  logic [SRC_W-1:0] num,
  output logic             ok,
  output logic [IDX_W-1:0] idx
);
  import irqsrc_pkg::*;

  assign ok  = in_window(32'(num), SRC_BASE, NUM_SRC);
  assign idx = IDX_W'(32'(num) - SRC_BASE);
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && step) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/irqsrc_slot.sv
module irqsrc_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_source_table.sv
module irq_source_table #(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int SRC_BASE    = 32'h1000,
  parameter int SRC_W       = 16,
  parameter int SRV_W       = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             in_ready,
  output logic             busy,
  input  logic             line_valid,
  input  logic [IDX_W-1:0] line_idx,
  input  logic             line_level,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [8:0]       cfg_prio,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [SRV_W-1:0] rsp_server,
  output logic [7:0]       rsp_prio,
  input  logic             rej_valid,
  input  logic [SRC_W-1:0] rej_src,
  input  logic             eoi_valid,
  input  logic [SRC_W-1:0] eoi_src,
  input  logic             resend_req,
  output logic             dlv_valid,
  output logic [SRC_W-1:0] dlv_src,
  output logic [SRV_W-1:0] dlv_server,
  output logic [7:0]       dlv_prio,
  input  logic             dlv_ready
);
  import irqsrc_pkg::*;

  localparam int DLV_W = SRC_W + SRV_W + 8;

  typedef struct packed {
    logic [SRV_W-1:0] srv;
    logic [7:0]       prio;
    logic [7:0]       saved;
    logic             asrt;
    logic             sent;
    logic             rej;
    logic             mpend;
  } ent_t;

  ent_t tbl [NUM_SRC];

  // source number decoders: 0 config, 1 refusal, 2 end of service
  logic [SRC_W-1:0] dec_num [3];
  logic             dec_ok  [3];
  logic [IDX_W-1:0] dec_idx [3];
  assign dec_num[0] = cfg_src;
  assign dec_num[1] = rej_src;
  assign dec_num[2] = eoi_src;

  for (genvar g = 0; g < 3; g++) begin : g_dec
    irqsrc_decode #(.SRC_W(SRC_W), .IDX_W(IDX_W), .SRC_BASE(SRC_BASE),
                    .NUM_SRC(NUM_SRC)) u_dec (
      .num(dec_num[g]), .ok(dec_ok[g]), .idx(dec_idx[g]));
  end

  // named events
  logic             ev_cfg, ev_rej, ev_eoi, ev_line, ev_resend, ev_step;
  logic             cfg_bad;
  logic [IDX_W-1:0] scan_idx;

  assign in_ready  = !busy && !dlv_valid;
  assign ev_step   = busy && !dlv_valid;
  assign ev_cfg    = in_ready && cfg_valid;
  assign ev_rej    = in_ready && !cfg_valid && rej_valid;
  assign ev_eoi    = in_ready && !cfg_valid && !rej_valid && eoi_valid;
  assign ev_line   = in_ready && !cfg_valid && !rej_valid && !eoi_valid && line_valid;
  assign ev_resend = in_ready && !cfg_valid && !rej_valid && !eoi_valid && !line_valid
                     && resend_req;
  assign cfg_bad   = !dec_ok[0] || ((cfg_op == OP_ROUTE) &&
                     ((32'(cfg_server) >= NUM_SERVERS) || cfg_prio[8]));

  irqsrc_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(ev_resend), .step(ev_step),
    .busy(busy), .idx(scan_idx));

  logic [IDX_W-1:0] t_idx;
  logic             t_lvl, wr, fire;
  ent_t             cur, nxt;

  always_comb begin
    if (ev_step)      t_idx = scan_idx;
    else if (ev_cfg)  t_idx = dec_idx[0];
    else if (ev_rej)  t_idx = dec_idx[1];
    else if (ev_eoi)  t_idx = dec_idx[2];
    else              t_idx = line_idx;
    cur   = tbl[t_idx];
    t_lvl = LEVEL_MASK[t_idx];
    nxt   = cur;
    wr    = 1'b0;
    fire  = 1'b0;
    if (ev_step) begin
      wr = 1'b1;
      if (t_lvl) begin
        if (level_fires(cur.prio, cur.asrt, cur.sent)) begin
          nxt.sent = 1'b1;
          fire     = 1'b1;
        end
      end else if (cur.rej) begin
        nxt.rej = 1'b0;
        fire    = prio_live(cur.prio);
      end
    end else if (ev_cfg && !cfg_bad && (cfg_op != OP_QUERY)) begin
      wr = 1'b1;
      case (cfg_op)
        OP_ROUTE: begin
          nxt.srv   = cfg_server;
          nxt.prio  = cfg_prio[7:0];
          nxt.saved = cfg_prio[7:0];
        end
        OP_MUTE: begin
          nxt.prio  = PRIO_OFF;
          nxt.saved = cur.prio;
        end
        default: begin
          nxt.prio  = cur.saved;
          nxt.saved = cur.saved;
        end
      endcase
      if (t_lvl) begin
        if (level_fires(nxt.prio, nxt.asrt, nxt.sent)) begin
          nxt.sent = 1'b1;
          fire     = 1'b1;
        end
      end else if (nxt.mpend && prio_live(nxt.prio)) begin
        nxt.mpend = 1'b0;
        fire      = 1'b1;
      end
    end else if (ev_rej && dec_ok[1]) begin
      wr       = 1'b1;
      nxt.rej  = 1'b1;
      nxt.sent = 1'b0;
    end else if (ev_eoi && dec_ok[2]) begin
      wr = 1'b1;
      if (t_lvl) nxt.sent = 1'b0;
    end else if (ev_line) begin
      wr = 1'b1;
      if (t_lvl) begin
        nxt.asrt = line_level;
        if (level_fires(nxt.prio, line_level, nxt.sent)) begin
          nxt.sent = 1'b1;
          fire     = 1'b1;
        end
      end else if (line_level) begin
        if (prio_live(cur.prio)) fire = 1'b1;
        else                     nxt.mpend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        tbl[i] <= '{srv: '0, prio: PRIO_OFF, saved: PRIO_OFF,
                    asrt: 1'b0, sent: 1'b0, rej: 1'b0, mpend: 1'b0};
      end
    end else if (wr) begin
      tbl[t_idx] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid  <= ev_cfg;
      rsp_err    <= ev_cfg && cfg_bad;
      rsp_server <= (ev_cfg && !cfg_bad) ? nxt.srv  : '0;
      rsp_prio   <= (ev_cfg && !cfg_bad) ? nxt.prio : '0;
    end
  end

  logic [DLV_W-1:0] dlv_din, dlv_dout;
  assign dlv_din = {SRC_W'(SRC_BASE + int'(t_idx)), nxt.srv, nxt.prio};

  irqsrc_slot #(.W(DLV_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(fire), .din(dlv_din), .ready(dlv_ready),
    .valid(dlv_valid), .dout(dlv_dout));

  assign {dlv_src, dlv_server, dlv_prio} = dlv_dout;
endmodule

// File: rtl/irqsrc_checker.sv
module irqsrc_checker #(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int SRC_BASE    = 32'h1000,
  parameter int SRC_W       = 16,
  parameter int SRV_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             cfg_valid,
  input logic             rej_valid,
  input logic             eoi_valid,
  input logic             line_valid,
  input logic             resend_req,
  input logic             ev_cfg,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [SRC_W-1:0] dlv_src,
  input logic [SRV_W-1:0] dlv_server,
  input logic [7:0]       dlv_prio
);
  assert_dlv_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_src) &&
                                $stable(dlv_server) && $stable(dlv_prio));

  assert_dlv_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != 8'hFF);

  assert_dlv_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (32'(dlv_server) < NUM_SERVERS) && (32'(dlv_src) >= SRC_BASE) &&
                  (32'(dlv_src) < SRC_BASE + NUM_SRC));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !in_ready |=> !rsp_valid);

  assert_one_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ev_cfg));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !dlv_valid);

  assert_single_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> $onehot0({cfg_valid, rej_valid, eoi_valid, line_valid, resend_req}));
endmodule

bind irq_source_table irqsrc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .SRC_BASE(SRC_BASE),
  .SRC_W(SRC_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .cfg_valid(cfg_valid),
  .rej_valid(rej_valid), .eoi_valid(eoi_valid), .line_valid(line_valid),
  .resend_req(resend_req), .ev_cfg(ev_cfg), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .dlv_src(dlv_src), .dlv_server(dlv_server), .dlv_prio(dlv_prio));

// File: tb/test_irq_source_table.sv
module test_irq_source_table;
  localparam int NS   = 8;
  localparam int NSV  = 4;
  localparam int BASE = 32'h1000;
  localparam logic [7:0] LVL = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_ready, busy;
  logic line_valid = 0, line_level = 0;
  logic [2:0] line_idx = 0;
  logic cfg_valid = 0;
  logic [1:0] cfg_op = 0;
  logic [15:0] cfg_src = 0;
  logic [7:0] cfg_server = 0;
  logic [8:0] cfg_prio = 0;
  logic rsp_valid, rsp_err;
  logic [7:0] rsp_server, rsp_prio;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0, dlv_ready = 0;
  logic [15:0] rej_src = 0, eoi_src = 0;
  logic dlv_valid;
  logic [15:0] dlv_src;
  logic [7:0] dlv_server, dlv_prio;

  always #5 clk = ~clk;

  irq_source_table #(.NUM_SRC(NS), .NUM_SERVERS(NSV), .SRC_BASE(BASE),
                     .SRC_W(16), .SRV_W(8), .LEVEL_MASK(LVL)) i_irq_source_table (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy),
    .line_valid(line_valid), .line_idx(line_idx), .line_level(line_level),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_src(cfg_src),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .resend_req(resend_req), .dlv_valid(dlv_valid),
    .dlv_src(dlv_src), .dlv_server(dlv_server), .dlv_prio(dlv_prio),
    .dlv_ready(dlv_ready));

  int vec = 0, bad = 0;
  int m_srv [NS], m_prio [NS], m_saved [NS];
  bit m_asrt [NS], m_sent [NS], m_rej [NS], m_mp [NS];
  int eq_src [NS], eq_srv [NS], eq_prio [NS];
  int n_exp;
  int unsigned rs = 32'h1234_5678;

  function automatic int unsigned rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // entry re-check after a configuration write (R7/R8)
  function automatic bit settle(input int i);
    if (LVL[i]) begin
      if (m_prio[i] != 255 && m_asrt[i] && !m_sent[i]) begin
        m_sent[i] = 1;
        return 1;
      end
    end else if (m_mp[i] && m_prio[i] != 255) begin
      m_mp[i] = 0;
      return 1;
    end
    return 0;
  endfunction

  task automatic wait_ready();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic check_dlv(input bit e, input int i, input string tag);
    chk(tag, dlv_valid, e, "dlv_valid");
    if (e && dlv_valid) begin
      chk(tag, dlv_src, BASE + i, "dlv_src");
      chk(tag, dlv_server, m_srv[i], "dlv_server");
      chk(tag, dlv_prio, m_prio[i], "dlv_prio");
    end
    if (dlv_valid) begin
      dlv_ready = 1;
      @(negedge clk);
      dlv_ready = 0;
    end
  endtask

  task automatic do_cfg(input int op, input int src, input int srv, input int prio,
                        input string tag);
    int i;
    bit bc, e;
    i  = src - BASE;
    bc = (src < BASE || src >= BASE + NS) || (op == 0 && (srv >= NSV || prio > 255));
    e  = 0;
    if (!bc) begin
      case (op)
        0: begin m_srv[i] = srv; m_prio[i] = prio; m_saved[i] = prio; end
        2: begin m_saved[i] = m_prio[i]; m_prio[i] = 255; end
        3: m_prio[i] = m_saved[i];
        default: ;
      endcase
      if (op != 1) e = settle(i);
    end
    wait_ready();
    cfg_valid = 1; cfg_op = op[1:0]; cfg_src = src[15:0];
    cfg_server = srv[7:0]; cfg_prio = prio[8:0];
    @(negedge clk);
    cfg_valid = 0;
    chk(tag, rsp_valid, 1, "rsp_valid");
    chk(bc ? "R9" : tag, rsp_err, bc, "rsp_err");
    if (!bc) begin
      chk(tag, rsp_server, m_srv[i], "rsp_server");
      chk(tag, rsp_prio, m_prio[i], "rsp_prio");
    end
    check_dlv(e, i, bc ? "R9" : tag);
  endtask

  task automatic do_line(input int i, input bit lv, input string tag);
    bit e;
    e = 0;
    if (LVL[i]) begin
      m_asrt[i] = lv;
      if (m_prio[i] != 255 && lv && !m_sent[i]) begin m_sent[i] = 1; e = 1; end
    end else if (lv) begin
      if (m_prio[i] != 255) e = 1;
      else m_mp[i] = 1;
    end
    wait_ready();
    line_valid = 1; line_idx = i[2:0]; line_level = lv;
    @(negedge clk);
    line_valid = 0;
    check_dlv(e, i, tag);
  endtask

  task automatic do_rej(input int src);
    int i;
    i = src - BASE;
    if (src >= BASE && src < BASE + NS) begin m_rej[i] = 1; m_sent[i] = 0; end
    wait_ready();
    rej_valid = 1; rej_src = src[15:0];
    @(negedge clk);
    rej_valid = 0;
    check_dlv(0, 0, "R4");
  endtask

  task automatic do_eoi(input int src);
    int i;
    i = src - BASE;
    if (src >= BASE && src < BASE + NS && LVL[i]) m_sent[i] = 0;
    wait_ready();
    eoi_valid = 1; eoi_src = src[15:0];
    @(negedge clk);
    eoi_valid = 0;
    check_dlv(0, 0, "R5");
  endtask

  task automatic do_resend(input string tag);
    int got;
    n_exp = 0;
    for (int k = 0; k < NS; k++) begin
      bit e;
      e = 0;
      if (LVL[k]) begin
        if (m_prio[k] != 255 && m_asrt[k] && !m_sent[k]) begin m_sent[k] = 1; e = 1; end
      end else if (m_rej[k]) begin
        m_rej[k] = 0;
        e = (m_prio[k] != 255);
      end
      if (e) begin
        eq_src[n_exp] = BASE + k; eq_srv[n_exp] = m_srv[k]; eq_prio[n_exp] = m_prio[k];
        n_exp++;
      end
    end
    wait_ready();
    resend_req = 1;
    @(negedge clk);
    resend_req = 0;
    chk("R11", busy, 1, "busy after replay start");
    cfg_valid = 1; cfg_op = 2'd1; cfg_src = 16'(BASE);
    @(negedge clk);
    cfg_valid = 0;
    chk("R11", rsp_valid, 0, "rsp while busy");
    got = 0;
    forever begin
      if (dlv_valid) begin
        if (got < n_exp) begin
          chk(tag, dlv_src, eq_src[got], "replay src");
          chk(tag, dlv_server, eq_srv[got], "replay server");
          chk(tag, dlv_prio, eq_prio[got], "replay prio");
        end
        got++;
        dlv_ready = 1;
      end else begin
        dlv_ready = 0;
        if (!busy) break;
      end
      @(negedge clk);
    end
    chk(tag, got, n_exp, "replay count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_srv[i] = 0; m_prio[i] = 255; m_saved[i] = 255;
      m_asrt[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", in_ready, 1, "in_ready");
    chk("R1", busy, 0, "busy");
    chk("R1", dlv_valid, 0, "dlv_valid");
    for (int i = 0; i < NS; i++) do_cfg(1, BASE + i, 0, 0, "R1");

    // R9 illegal requests, then state unchanged
    do_cfg(1, BASE - 1, 0, 0, "R9");
    do_cfg(1, BASE + NS, 0, 0, "R9");
    do_cfg(0, BASE + 1, NSV, 5, "R9");
    do_cfg(0, BASE + 1, 1, 256, "R9");
    do_cfg(1, BASE + 1, 0, 0, "R9");

    // R2 message: masked event latched, route releases it, then immediate
    do_line(1, 1, "R2");
    do_cfg(0, BASE + 1, 2, 5, "R7");
    do_line(1, 1, "R2");
    do_line(1, 0, "R2");

    // R3/R5 level source
    do_cfg(0, BASE + 5, 3, 7, "R7");
    do_line(5, 1, "R3");
    do_line(5, 1, "R3");
    do_eoi(BASE + 5);
    do_line(5, 1, "R3");
    do_eoi(BASE + 1);

    // R4/R6 refusal then replay
    do_rej(BASE + 5);
    do_rej(BASE + 1);
    do_resend("R4");
    do_resend("R6");

    // R8 mute/unmute
    do_cfg(0, BASE + 2, 1, 9, "R7");
    do_cfg(2, BASE + 2, 0, 0, "R8");
    do_line(2, 1, "R8");
    do_cfg(3, BASE + 2, 0, 0, "R8");
    do_cfg(2, BASE + 5, 0, 0, "R8");
    do_eoi(BASE + 5);
    do_cfg(3, BASE + 5, 0, 0, "R8");

    // R12/R11 hold delivery while stalled
    do_cfg(0, BASE + 0, 1, 3, "R7");
    wait_ready();
    line_valid = 1; line_idx = 0; line_level = 1;
    @(negedge clk);
    line_valid = 0;
    cfg_valid = 1; cfg_op = 2'd1; cfg_src = 16'(BASE);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R12", dlv_valid, 1, "held valid");
      chk("R12", dlv_src, BASE, "held src");
      chk("R12", dlv_prio, 3, "held prio");
      chk("R11", rsp_valid, 0, "stalled rsp");
      chk("R11", in_ready, 0, "in_ready");
    end
    cfg_valid = 0;
    check_dlv(1, 0, "R12");
    chk("R12", dlv_valid, 0, "slot emptied");

    // pseudo-random sweep against the model
    for (int n = 0; n < 900; n++) begin
      int unsigned r, sel, src, prio;
      r   = rnd();
      sel = r % 16;
      src = BASE - 1 + ((r >> 4) % 10);
      prio = ((r >> 8) % 5 == 0) ? 255 : (((r >> 8) % 23 == 0) ? 256 : (r >> 12) % 32);
      if (sel < 5) begin
        int i;
        i = (r >> 4) % NS;
        do_line(i, (r >> 9) & 1, LVL[i] ? "R3" : "R2");
      end else if (sel < 9) begin
        int op;
        op = (r >> 20) % 4;
        do_cfg(op, src, (r >> 24) % 5, prio, op == 0 ? "R7" : (op == 1 ? "R10" : "R8"));
      end else if (sel < 11) do_rej(src);
      else if (sel < 13) do_eoi(src);
      else if (sel == 13) do_resend("R6");
      else do_cfg(1, src, 0, 0, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule